// File: doc/BRIEF.md
# Comparator-Feedback Average Current Sensor

This block is the digital half of a closed-loop average inductor current sensor. An external comparator compares the sensed inductor current with an analog threshold that a DAC derives from this block's output word. A second comparator reports whether the inductor current is still above zero. On every fast-clock cycle the block counts how long each comparator stays high within one switching period. The switching period is marked by a strobe from the PWM.

At each period boundary the two counts are captured. The main comparator count is the measured duty ratio. The zero-current count is the conduction fraction c. From c the block computes the reference duty ratio c·(1 − c/2). In continuous conduction c is the whole period and the reference becomes one half. In discontinuous conduction the reference shrinks, so the same loop stays correct in both modes.

The difference between the measured and the reference duty ratio is multiplied by a programmable fractional gain and added into a saturating integrator. The integrator's upper bits are the sensed current word. A one-clock strobe marks each period in which that word changed.

Top module: `avg_isense`

## Requirements
- R1: The duty count is the number of fast-clock cycles in a period during which the main comparator input is high. It saturates at 2^W, which stands for a ratio of 1.0 (2^W = 1024 at the default W = 10).
- R2: The conduction count runs from the period start until the first cycle in which the zero-current input is low, and then stays frozen for the rest of that period even if the input rises again. It saturates at 2^W.
- R3: The reference duty count is c − floor(c·c / 2^(W+1)), where c is the conduction count. A full-period conduction (c = 2^W) gives 2^(W−1). With c = 600 it gives 425, and with c = 0 it gives 0.
- R4: Once per period the integrator adds K·(duty − reference). K is the unsigned loop_gain input divided by 2^KF, where KF = 8. The accumulator holds W integer bits and KF fractional bits, and isense is its upper W bits.
- R5: The accumulator saturates at 0 and at 2^(W+KF) − 1 instead of wrapping.
- R6: isense_valid is high for exactly one clock, in the cycle after an update that changed isense. It stays low after an update that left isense unchanged.
- R7: Both comparator inputs pass through two synchronizer flops, and the period strobe is delayed by the same two cycles. If period_start is high before clock edge 0, the counts of the period just ended are captured at edge 2, and isense takes its new value at edge 3.
- R8: While rst_n is low, isense is 0, isense_valid is 0, and both counts and the integrator are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_start | input | 1 | One-clock strobe at the start of each switching period |
| cmp_main | input | 1 | Main comparator output, asynchronous |
| cmp_zero | input | 1 | Zero-current comparator output, high while current flows, asynchronous |
| loop_gain | input | K_W | Integrator gain K in units of 2^-8 |
| isense | output | W | Sensed average current word |
| isense_valid | output | 1 | One-clock strobe when isense changed |

## Verification
A switching period's counts first affect isense three clock edges after the following period strobe. isense_valid follows on that same edge. The bench therefore drives each period in full and compares isense against its model, which applies the previous period's counts with the current gain. It does this twice in every period: at the fourth negative edge, where the old value must still hold, and at the last negative edge, where the new value must be present. It counts isense_valid pulses over the whole period so that a missing or doubled strobe shows up. Saturation of the counts uses periods longer than 2^W clocks. The frozen conduction count uses a zero-current input that rises again after it has gone low.

// File: rtl/avg_isense.sv
module avg_isense #(
  parameter int W   = 10,
  parameter int K_W = 8,
  parameter int K_F = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           period_start,
  input  logic           cmp_main,
  input  logic           cmp_zero,
  input  logic [K_W-1:0] loop_gain,
  output logic [W-1:0]   isense,
  output logic           isense_valid
);
  localparam int CW    = W + 1;
  localparam int ACC_W = W + K_F;
  localparam int SUM_W = ACC_W + K_W + 4;
  localparam logic [CW-1:0] FULL = CW'(1) << W;

  logic [1:0] main_sy, zero_sy, st_d;
  logic [CW-1:0] dp_cnt, ref_cnt, dp_lat, ref_lat;
  logic run, upd;
  logic [ACC_W-1:0] acc, nxt;

  wire main_s = main_sy[1];
  wire zero_s = zero_sy[1];
  wire st     = st_d[1];

  // two-flop synchronizers; strobe delayed equally to stay aligned (R7)
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      main_sy <= '0;
      zero_sy <= '0;
      st_d    <= '0;
    end else begin
      main_sy <= {main_sy[0], cmp_main};
      zero_sy <= {zero_sy[0], cmp_zero};
      st_d    <= {st_d[0], period_start};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dp_cnt  <= '0;
      ref_cnt <= '0;
      dp_lat  <= '0;
      ref_lat <= '0;
      run     <= 1'b0;
      upd     <= 1'b0;
    end else begin
      upd <= st;
      if (st) begin
        dp_lat  <= dp_cnt;
        ref_lat <= ref_cnt;
        dp_cnt  <= CW'(main_s);
        ref_cnt <= CW'(zero_s);
        run     <= zero_s;
      end else begin
        if (main_s && dp_cnt != FULL) dp_cnt <= dp_cnt + 1'b1;
        if (run) begin
          if (!zero_s) run <= 1'b0;
          else if (ref_cnt != FULL) ref_cnt <= ref_cnt + 1'b1;
        end
      end
    end

  logic [2*CW-1:0] sq;
  logic [CW-1:0] dref;
  logic signed [CW+1:0] err;
  logic signed [SUM_W-1:0] err_x, k_x, sum;

  assign sq    = ref_lat * ref_lat;
  assign dref  = ref_lat - CW'(sq >> (W + 1));
  assign err   = $signed({1'b0, dp_lat}) - $signed({1'b0, dref});
  assign err_x = SUM_W'(err);
  assign k_x   = $signed({{(SUM_W-K_W){1'b0}}, loop_gain});
  assign sum   = $signed({{(SUM_W-ACC_W){1'b0}}, acc}) + err_x * k_x;

  always_comb
    if (sum < 0)
      nxt = '0;
    else if (sum > $signed({{(SUM_W-ACC_W){1'b0}}, {ACC_W{1'b1}}}))
      nxt = '1;
    else
      nxt = sum[ACC_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc          <= '0;
      isense_valid <= 1'b0;
    end else if (upd) begin
      acc          <= nxt;
      isense_valid <= (nxt[ACC_W-1:K_F] != acc[ACC_W-1:K_F]);
    end else begin
      isense_valid <= 1'b0;
    end

  assign isense = acc[ACC_W-1:K_F];

  assert_dp_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dp_cnt <= FULL);

  assert_ref_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !st) |=> $stable(ref_cnt));

  assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd) |-> $stable(isense));

  assert_no_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(err) > 0) |-> acc >= $past(acc));

  assert_no_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd) && $past(err) < 0) |-> acc <= $past(acc));

  assert_valid_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    isense_valid |-> isense != $past(isense));
endmodule

// File: tb/avg_isense_tb.sv
`timescale 1ns/1ps
module avg_isense_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_start = 1'b0, cmp_main = 1'b0, cmp_zero = 1'b0;
  logic [7:0] loop_gain = '0;
  logic [9:0] isense;
  logic isense_valid;

  int total = 0, bad = 0, vcnt = 0;
  int acc_m = 0, prev_h = 0, prev_c = 0;

  always #2.5 clk = ~clk;

  avg_isense u_dut (
    .clk(clk), .rst_n(rst_n), .period_start(period_start),
    .cmp_main(cmp_main), .cmp_zero(cmp_zero), .loop_gain(loop_gain),
    .isense(isense), .isense_valid(isense_valid)
  );

  always @(negedge clk) if (isense_valid) vcnt++;

  function automatic string tagname(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one switching period of n clocks; main high for h, zero high for c,
  // then optionally high again from c+10 for rez clocks
  task automatic run_period(int n, int h, int c, int rez, int k, string tag);
    int dp, r, dref, a, old_o, new_o;
    dp = (prev_h > 1024) ? 1024 : prev_h;
    r  = (prev_c > 1024) ? 1024 : prev_c;
    dref = r - ((r * r) >> 11);
    a = acc_m + k * (dp - dref);
    if (a < 0) a = 0;
    if (a > 262143) a = 262143;
    old_o = acc_m >> 8;
    new_o = a >> 8;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) vcnt = 0;
      if (i == 3) check("R7 before update", int'(isense), old_o);
      if (i == n - 1) begin
        check(tag, int'(isense), new_o);
        check("R6 valid pulses", vcnt, (new_o != old_o) ? 1 : 0);
      end
      period_start = (i == 0);
      cmp_main  = (i < h);
      cmp_zero  = (i < c) || (rez > 0 && i >= c + 10 && i < c + 10 + rez);
      loop_gain = 8'(k);
    end
    acc_m = a;
    prev_h = h;
    prev_c = c;
  endtask

  localparam int NV = 22;
  // n, h, c, rez, k, requirement tag
  localparam int TAB [NV][6] = '{
    '{1024, 512, 1024, 0, 26, 3},   // R3 CCM equilibrium
    '{1024, 512, 1024, 0, 26, 3},
    '{1024, 700, 1024, 0, 26, 3},
    '{1024, 700, 1024, 0, 26, 4},   // R4 ramp up
    '{1024, 300, 1024, 0, 6,  4},   // R4 smaller gain
    '{1024, 425, 600,  0, 26, 4},   // R4 ramp down
    '{1024, 425, 600,  0, 26, 3},   // R3 DCM equilibrium
    '{1024, 100, 300, 40, 26, 3},
    '{1024, 100, 300,  0, 26, 2},   // R2 frozen after glitch
    '{1030, 1030, 1030, 0, 255, 2},
    '{1030, 1030, 1030, 0, 255, 1}, // R1 counts capped
    '{1030, 1030, 1030, 0, 255, 5},
    '{1030, 1030, 1030, 0, 255, 5},
    '{1024, 0, 1024, 0, 255, 5},    // R5 top saturation
    '{1024, 0, 1024, 0, 255, 5},
    '{1024, 0, 1024, 0, 255, 5},
    '{1024, 0, 1024, 0, 255, 5},
    '{1024, 0, 1024, 0, 255, 5},    // R5 bottom saturation
    '{1024, 0, 0, 0, 26, 5},
    '{1024, 3, 1024, 0, 1, 3},      // R3 c=0 gives zero reference
    '{1024, 3, 1024, 0, 1, 3},
    '{1024, 0, 0, 0, 1, 5}          // R5 stays at 0
  };

  initial begin : watchdog
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset isense", int'(isense), 0);
    check("R8 reset valid", int'(isense_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run_period(TAB[v][0], TAB[v][1], TAB[v][2], TAB[v][3], TAB[v][4],
                 tagname(TAB[v][5]));

    // directed: ramp, then reset mid-period (R8)
    run_period(1024, 900, 1024, 0, 60, "R4 directed ramp");
    run_period(1024, 900, 1024, 0, 60, "R4 directed ramp");
    run_period(1024, 900, 1024, 0, 60, "R4 directed ramp");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid-run reset isense", int'(isense), 0);
    check("R8 mid-run reset valid", int'(isense_valid), 0);
    rst_n = 1'b1;
    acc_m = 0; prev_h = 0; prev_c = 0;
    cmp_main = 1'b0; cmp_zero = 1'b0;
    repeat (4) @(negedge clk);
    run_period(1024, 512, 1024, 0, 60, "R8 counts cleared by reset");
    run_period(1024, 512, 1024, 0, 60, "R3 equilibrium after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule